// File: doc/BRIEF.md
# Streaming Interest-Point Extractor

This block takes a raster image as a stream of small unsigned pixels, one per accepted beat. It keeps enough past pixels in a chain of registers to see a square window around every pixel. For each window centre it adds up the absolute differences between neighbouring pixels along four lines through the centre: across, down, and the two diagonals. The smallest of the four sums is that pixel's interest score. A corner or textured spot scores high. An edge scores low, because at least one direction runs along the edge.

The frame is cut into horizontal strips of equal height. Within each strip the block keeps the highest score seen so far and the raster address of the pixel that gave it. When the strip's last centre has been scored, that address is written into one entry of a feature bank. There are two banks, used in turn frame by frame. One bank is being filled while the other still holds the previous frame's features for a downstream matcher, which reads them through a combinational read port. A one-cycle pulse marks the moment the last strip of a frame has been stored.

The input is a valid/ready stream. The block never applies back-pressure: ready is held high and a beat happens on every clock where valid is high. The upstream source may insert idle cycles freely. The strip height (image side / strip count) must exceed half the window size.

Top module: `interest_point_extractor`

## Requirements
- R1: After reset, `px_ready` is 1, `frame_done` is 0, `fill_bank` is 0, and every entry of both banks reads 0.
- R2: A pixel is consumed only on a clock where `px_valid` is high. Cycles with `px_valid` low leave all results unchanged, whatever `px_data` and `px_sof` carry.
- R3: With window side Q (default 7) and h = (Q-1)/2, a centre's score is the minimum of four sums. Each sum covers the Q-1 absolute differences between consecutive pixels on one line of Q pixels through the centre. The lines are: row offsets 0 with column offsets -h..h; column offset 0 with row offsets -h..h; points (row -i, col +i); and points (row +i, col +i), for i = -h..h.
- R4: A centre whose row or column lies within h of any image edge scores 0, so it can never be stored as a feature.
- R5: The running best of a strip is replaced only by a strictly larger score. When scores tie, the earlier pixel in raster order is kept.
- R6: Strip k holds centre rows k*SH .. k*SH+SH-1, where SH = DIM/N. Bank entry k holds the address row*DIM + col of that strip's best centre, with the row in the upper half of the address bits and the column in the lower half. Each strip starts its search from a cleared best.
- R7: A strip in which no centre scores above 0 stores address 0.
- R8: The frame that completes first after reset fills bank 0, the next fills bank 1, and so on. `fill_bank` names the bank being filled and flips together with `frame_done`. The other bank keeps its contents, and `rd_addr` shows entry `rd_idx` of bank `rd_bank` combinationally.
- R9: `frame_done` is high for exactly one cycle. It rises at the clock edge after the edge that accepts the pixel at address DIM*DIM-1, and all N entries for that frame are readable from that cycle on.
- R10: A beat with `px_sof` high gives its pixel address 0 and clears the running best, even in the middle of a frame. An abandoned partial frame produces no `frame_done` pulse and does not switch banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | Pixel beat valid |
| px_ready | output | 1 | Always 1; the block never stalls |
| px_data | input | PIX_W | Unsigned pixel value |
| px_sof | input | 1 | Marks the first pixel of a frame (sampled on beats only) |
| rd_bank | input | 1 | Bank selected for reading |
| rd_idx | input | LOG2_N | Strip entry selected for reading |
| rd_addr | output | 2*LOG2_DIM | Stored feature address {row, col} |
| fill_bank | output | 1 | Bank the current frame writes into |
| frame_done | output | 1 | One-cycle pulse after the last strip is stored |

## Verification
The assertions check four things on every cycle. An interior score never exceeds, and always equals, one of the four directional sums. The running best only falls right after a strip store or a frame restart. The completion pulse lasts one cycle and follows a last-pixel beat. The bank selector moves exactly when that pulse fires. The bench scenarios are needed for the rest: the stored addresses across whole frames, where border masking, tie order, strip partitioning and empty strips each leave their trace. The same goes for idle cycles carrying junk data, and for a frame abandoned mid-way and restarted. These results only show up after hundreds of beats, compared against an independent model of each frame.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

  typedef enum logic [1:0] {
    DIR_ACROSS = 2'd0,
    DIR_DOWN   = 2'd1,
    DIR_RISE   = 2'd2,
    DIR_FALL   = 2'd3
  } ipx_dir_e;

  // Row offset of step t (0..Q-1) along direction d, h = half window.
  function automatic int step_dy(int d, int t, int h);
    case (ipx_dir_e'(d))
      DIR_ACROSS: return 0;
      DIR_DOWN:   return t - h;
      DIR_RISE:   return h - t;
      default:    return t - h;
    endcase
  endfunction

  // Column offset of step t along direction d.
  function automatic int step_dx(int d, int t, int h);
    case (ipx_dir_e'(d))
      DIR_ACROSS: return t - h;
      DIR_DOWN:   return 0;
      default:    return t - h;
    endcase
  endfunction

endpackage

// File: rtl/ipx_window.sv
module ipx_window #(
  parameter int PW  = 5,
  parameter int DIM = 16,
  parameter int Q   = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  logic [PW-1:0]         pix,
  output logic [4*Q*PW-1:0]     lines
);
  import ipx_pkg::*;

  localparam int H     = (Q - 1) / 2;
  localparam int DEPTH = (Q - 1) * DIM + Q;

  // Chain of Q-1 full image lines plus Q pixels; entry 0 is the newest.
  logic [PW-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chain_q[i] <= '0;
    end else if (beat) begin
      chain_q[0] <= pix;
      for (int i = 1; i < DEPTH; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  // Pixel at (dy, dx) from the centre sits (h-dy) lines and (h-dx) pixels back.
  for (genvar d = 0; d < 4; d++) begin : g_dir
    for (genvar t = 0; t < Q; t++) begin : g_tap
      localparam int DY = step_dy(d, t, H);
      localparam int DX = step_dx(d, t, H);
      assign lines[(d*Q + t)*PW +: PW] = chain_q[(H - DY)*DIM + (H - DX)];
    end
  end

endmodule

// File: rtl/ipx_dirsum.sv
module ipx_dirsum #(
  parameter int PW = 5,
  parameter int Q  = 7,
  parameter int SW = 8
) (
  input  logic [Q*PW-1:0] line,
  output logic [SW-1:0]   sum
);
  logic [SW-1:0] acc;
  logic [PW-1:0] pa, pb;

  always_comb begin
    acc = '0;
    pa  = '0;
    pb  = '0;
    for (int t = 0; t < Q - 1; t++) begin
      pa  = line[t*PW +: PW];
      pb  = line[(t+1)*PW +: PW];
      acc = acc + SW'((pa > pb) ? (pa - pb) : (pb - pa));
    end
  end

  assign sum = acc;

endmodule

// File: rtl/ipx_min4.sv
module ipx_min4 #(
  parameter int SW = 8
) (
  input  logic [4*SW-1:0] sums,
  output logic [SW-1:0]   minv
);
  logic [SW-1:0] s0, s1, s2, s3, m01, m23;

  assign s0  = sums[0*SW +: SW];
  assign s1  = sums[1*SW +: SW];
  assign s2  = sums[2*SW +: SW];
  assign s3  = sums[3*SW +: SW];
  assign m01 = (s1 < s0) ? s1 : s0;
  assign m23 = (s3 < s2) ? s3 : s2;
  assign minv = (m23 < m01) ? m23 : m01;

endmodule

// File: rtl/ipx_strip_track.sv
module ipx_strip_track #(
  parameter int LOG2_DIM = 4,
  parameter int LOG2_N   = 2,
  parameter int SW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stg_vld,
  input  logic                  stg_sof,
  input  logic                  stg_last,
  input  logic                  stg_cval,
  input  logic [2*LOG2_DIM-1:0] ctr,
  input  logic [SW-1:0]         score,
  input  logic                  rd_bank,
  input  logic [LOG2_N-1:0]     rd_idx,
  output logic [2*LOG2_DIM-1:0] rd_addr,
  output logic                  fill_bank,
  output logic                  done,
  output logic [SW-1:0]         run_max,
  output logic                  clr_evt
);
  localparam int AW  = 2 * LOG2_DIM;
  localparam int N   = 1 << LOG2_N;
  localparam int SLB = AW - LOG2_N;  // address bits inside one strip

  logic [SW-1:0]     max_q, nxt_max;
  logic [AW-1:0]     ck_q, nxt_ck;
  logic [AW-1:0]     bank_q [2][N];
  logic              take, strip_end, commit;
  logic [LOG2_N-1:0] cidx;

  assign take      = score > max_q;
  assign nxt_max   = take ? score : max_q;
  assign nxt_ck    = take ? ctr : ck_q;
  assign strip_end = stg_cval && (&ctr[SLB-1:0]) && (ctr[AW-1:SLB] != LOG2_N'(N - 1));
  assign commit    = stg_vld && !stg_sof && (strip_end || stg_last);
  assign cidx      = stg_last ? LOG2_N'(N - 1) : ctr[AW-1:SLB];
  assign clr_evt   = stg_vld && (stg_sof || commit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q     <= '0;
      ck_q      <= '0;
      fill_bank <= 1'b0;
      done      <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < N; k++) bank_q[b][k] <= '0;
    end else begin
      done <= stg_vld && stg_last;
      if (stg_vld) begin
        if (stg_sof) begin
          max_q <= '0;
          ck_q  <= '0;
        end else if (commit) begin
          bank_q[fill_bank][cidx] <= nxt_ck;
          max_q <= '0;
          ck_q  <= '0;
        end else begin
          max_q <= nxt_max;
          ck_q  <= nxt_ck;
        end
        if (stg_last) fill_bank <= ~fill_bank;
      end
    end
  end

  assign rd_addr = bank_q[rd_bank][rd_idx];
  assign run_max = max_q;

endmodule

// File: rtl/interest_point_extractor.sv
module interest_point_extractor #(
  parameter int PIX_W    = 5,
  parameter int LOG2_DIM = 4,
  parameter int Q        = 7,
  parameter int LOG2_N   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  px_valid,
  output logic                  px_ready,
  input  logic [PIX_W-1:0]      px_data,
  input  logic                  px_sof,
  input  logic                  rd_bank,
  input  logic [LOG2_N-1:0]     rd_idx,
  output logic [2*LOG2_DIM-1:0] rd_addr,
  output logic                  fill_bank,
  output logic                  frame_done
);
  localparam int DIM  = 1 << LOG2_DIM;
  localparam int AW   = 2 * LOG2_DIM;
  localparam int H    = (Q - 1) / 2;
  localparam int OFF  = H * DIM + H;
  localparam int LAST = DIM * DIM - 1;
  localparam int SW   = PIX_W + $clog2(Q);

  logic              beat;
  logic [AW-1:0]     addr_q, cur_addr;
  logic              stg_vld, stg_sof, stg_last;
  logic [AW-1:0]     stg_addr, ctr;
  logic              stg_cval, interior;
  logic [LOG2_DIM-1:0] cx, cy;
  logic [4*Q*PIX_W-1:0] lines;
  logic [4*SW-1:0]   sums;
  logic [SW-1:0]     minv, score;
  logic [SW-1:0]     run_max;
  logic              clr_evt;

  assign px_ready = 1'b1;
  assign beat     = px_valid;
  assign cur_addr = px_sof ? '0 : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stg_vld  <= 1'b0;
      stg_sof  <= 1'b0;
      stg_last <= 1'b0;
      stg_addr <= '0;
    end else begin
      stg_vld <= beat;
      if (beat) begin
        addr_q   <= cur_addr + AW'(1);
        stg_addr <= cur_addr;
        stg_sof  <= px_sof;
        stg_last <= (cur_addr == AW'(LAST));
      end
    end
  end

  ipx_window #(.PW(PIX_W), .DIM(DIM), .Q(Q)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .pix   (px_data),
    .lines (lines)
  );

  for (genvar d = 0; d < 4; d++) begin : g_sum
    ipx_dirsum #(.PW(PIX_W), .Q(Q), .SW(SW)) u_sum (
      .line (lines[d*Q*PIX_W +: Q*PIX_W]),
      .sum  (sums[d*SW +: SW])
    );
  end

  ipx_min4 #(.SW(SW)) u_min (
    .sums (sums),
    .minv (minv)
  );

  // Centre of the window lags the newest pixel by h lines and h pixels.
  assign ctr      = stg_addr - AW'(OFF);
  assign stg_cval = stg_addr >= AW'(OFF);
  assign cx       = ctr[LOG2_DIM-1:0];
  assign cy       = ctr[AW-1:LOG2_DIM];
  assign interior = stg_cval
                 && (cx >= LOG2_DIM'(H)) && (cx <= LOG2_DIM'(DIM - 1 - H))
                 && (cy >= LOG2_DIM'(H)) && (cy <= LOG2_DIM'(DIM - 1 - H));
  assign score    = interior ? minv : '0;

  ipx_strip_track #(.LOG2_DIM(LOG2_DIM), .LOG2_N(LOG2_N), .SW(SW)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stg_vld   (stg_vld),
    .stg_sof   (stg_sof),
    .stg_last  (stg_last),
    .stg_cval  (stg_cval),
    .ctr       (ctr),
    .score     (score),
    .rd_bank   (rd_bank),
    .rd_idx    (rd_idx),
    .rd_addr   (rd_addr),
    .fill_bank (fill_bank),
    .done      (frame_done),
    .run_max   (run_max),
    .clr_evt   (clr_evt)
  );

endmodule

// File: rtl/ipx_checker.sv
module ipx_checker #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic          fill_bank,
  input logic [4*SW-1:0] dir_sums,
  input logic [SW-1:0] score,
  input logic          interior,
  input logic [SW-1:0] run_max,
  input logic          clr_evt,
  input logic          stg_vld,
  input logic          stg_last
);
  logic [SW-1:0] s0, s1, s2, s3;
  assign s0 = dir_sums[0*SW +: SW];
  assign s1 = dir_sums[1*SW +: SW];
  assign s2 = dir_sums[2*SW +: SW];
  assign s3 = dir_sums[3*SW +: SW];

  AST_SCORE_NOT_ABOVE_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
    interior |-> (score <= s0 && score <= s1 && score <= s2 && score <= s3)); // R3

  AST_SCORE_IS_A_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    interior |-> (score == s0 || score == s1 || score == s2 || score == s3)); // R3

  AST_BEST_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_max < $past(run_max)) |-> $past(clr_evt)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(stg_vld && stg_last)); // R9

  AST_BANK_FLIPS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (fill_bank != $past(fill_bank))); // R8

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> (fill_bank == $past(fill_bank))); // R8

endmodule

bind interest_point_extractor ipx_checker #(.SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_done (frame_done),
  .fill_bank  (fill_bank),
  .dir_sums   (sums),
  .score      (score),
  .interior   (interior),
  .run_max    (run_max),
  .clr_evt    (clr_evt),
  .stg_vld    (stg_vld),
  .stg_last   (stg_last)
);

// File: tb/interest_point_extractor_test.sv
module interest_point_extractor_test;
  localparam int PW = 5;
  localparam int LOG2_DIM = 4;
  localparam int DIM = 1 << LOG2_DIM;
  localparam int Q = 7;
  localparam int H = (Q - 1) / 2;
  localparam int LOG2_N = 2;
  localparam int N = 1 << LOG2_N;
  localparam int SH = DIM / N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic px_valid = 1'b0;
  logic px_ready;
  logic [PW-1:0] px_data = '0;
  logic px_sof = 1'b0;
  logic rd_bank = 1'b0;
  logic [LOG2_N-1:0] rd_idx = '0;
  logic [2*LOG2_DIM-1:0] rd_addr;
  logic fill_bank;
  logic frame_done;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int frame [DIM*DIM];
  int saved [N];

  always #2 clk = ~clk;

  interest_point_extractor #(.PIX_W(PW), .LOG2_DIM(LOG2_DIM), .Q(Q), .LOG2_N(LOG2_N)) uut (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .px_sof(px_sof), .rd_bank(rd_bank), .rd_idx(rd_idx),
    .rd_addr(rd_addr), .fill_bank(fill_bank), .frame_done(frame_done)
  );

  always @(negedge clk) if (rst_n && frame_done) n_done++;

  // ---------------- reference model ----------------
  function automatic int pix_at(int y, int x);
    return frame[y*DIM + x];
  endfunction

  function automatic int dir_sum(int y, int x, int d);
    int s = 0;
    for (int t = 0; t < Q - 1; t++) begin
      int ya, xa, yb, xb, va, vb;
      case (d)
        0: begin ya = y;         xa = x + t - H; yb = y;           xb = x + t + 1 - H; end
        1: begin ya = y + t - H; xa = x;         yb = y + t + 1 - H; xb = x;           end
        2: begin ya = y + H - t; xa = x + t - H; yb = y + H - t - 1; xb = x + t + 1 - H; end
        default: begin ya = y + t - H; xa = x + t - H; yb = y + t + 1 - H; xb = x + t + 1 - H; end
      endcase
      va = pix_at(ya, xa);
      vb = pix_at(yb, xb);
      s += (va > vb) ? va - vb : vb - va;
    end
    return s;
  endfunction

  function automatic int interest(int y, int x);
    int m;
    if (y < H || y > DIM - 1 - H || x < H || x > DIM - 1 - H) return 0;
    m = dir_sum(y, x, 0);
    for (int d = 1; d < 4; d++) if (dir_sum(y, x, d) < m) m = dir_sum(y, x, d);
    return m;
  endfunction

  function automatic int exp_addr(int k);
    int best = 0;
    int where = 0;
    for (int y = k*SH; y < k*SH + SH; y++)
      for (int x = 0; x < DIM; x++) begin
        int v = interest(y, x);
        if (v > best) begin best = v; where = y*DIM + x; end
      end
    return where;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic rd(input int b, input int k, output int v);
    rd_bank = b[0];
    rd_idx = LOG2_N'(k);
    #1;
    v = int'(rd_addr);
  endtask

  task automatic drive_frame(input int bub, input int stop_at);
    for (int a = 0; a < DIM*DIM; a++) begin
      if (stop_at >= 0 && a == stop_at) return;
      while (bub > 0 && int'($urandom_range(99)) < bub) begin
        @(negedge clk);
        px_valid = 1'b0;
        px_data = PW'($urandom);
        px_sof = $urandom_range(1);
      end
      @(negedge clk);
      px_valid = 1'b1;
      px_data = PW'(frame[a]);
      px_sof = (a == 0);
    end
    @(negedge clk);
    px_valid = 1'b0;
    px_sof = 1'b0;
  endtask

  // Called at the negedge after the edge that accepted the last pixel.
  task automatic finish_frame(input int bank, input string req);
    int v;
    check(frame_done == 1'b0, "R9", "done before store edge", frame_done, 0);
    @(negedge clk);
    check(frame_done == 1'b1, "R9", "done after last pixel", frame_done, 1);
    check(fill_bank == !bank[0], "R8", "fill bank flipped", fill_bank, !bank[0]);
    for (int k = 0; k < N; k++) begin
      rd(bank, k, v);
      check(v == exp_addr(k), req, $sformatf("bank %0d entry %0d", bank, k), v, exp_addr(k));
    end
    @(negedge clk);
    check(frame_done == 1'b0, "R9", "done single cycle", frame_done, 0);
  endtask

  task automatic fill_rand(input int maxv);
    for (int i = 0; i < DIM*DIM; i++) frame[i] = int'($urandom_range(maxv));
  endtask

  task automatic save_model();
    for (int k = 0; k < N; k++) saved[k] = exp_addr(k);
  endtask

  task automatic check_saved(input int bank, input string req);
    int v;
    for (int k = 0; k < N; k++) begin
      rd(bank, k, v);
      check(v == saved[k], req, $sformatf("untouched bank %0d entry %0d", bank, k), v, saved[k]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  // ---------------- scenarios ----------------
  initial begin
    int v, d0;
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(px_ready == 1'b1, "R1", "ready after reset", px_ready, 1);
    check(frame_done == 1'b0, "R1", "done after reset", frame_done, 0);
    check(fill_bank == 1'b0, "R1", "fill bank after reset", fill_bank, 0);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < N; k++) begin
        rd(b, k, v);
        check(v == 0, "R1", $sformatf("bank %0d entry %0d after reset", b, k), v, 0);
      end

    // Frame A: random, no idle cycles -> bank 0 (R3, R6, R8, R9)
    fill_rand(31);
    save_model();
    drive_frame(0, -1);
    finish_frame(0, "R3/R6");
    for (int k = 0; k < N; k++) begin
      rd(1, k, v);
      check(v == 0, "R8", $sformatf("bank 1 entry %0d untouched", k), v, 0);
    end

    // Frame B: random with idle cycles carrying junk -> bank 1 (R2), bank 0 kept (R8)
    fill_rand(31);
    drive_frame(30, -1);
    finish_frame(1, "R2");
    check_saved(0, "R8");
    check(px_ready == 1'b1, "R2", "ready stays high", px_ready, 1);

    // Frame C: texture only in rows 0..1, flat elsewhere -> border masked (R4)
    for (int i = 0; i < DIM*DIM; i++) frame[i] = (i < 2*DIM) ? int'($urandom_range(31)) : 0;
    drive_frame(0, -1);
    finish_frame(0, "R4");
    rd(0, 0, v);
    check(v == 0, "R4", "strip 0 with only border texture", v, 0);

    // Frame D: constant image -> every strip stores 0 (R7)
    for (int i = 0; i < DIM*DIM; i++) frame[i] = 17;
    drive_frame(0, -1);
    finish_frame(1, "R7");
    for (int k = 0; k < N; k++) begin
      rd(1, k, v);
      check(v == 0, "R7", $sformatf("flat strip %0d", k), v, 0);
    end

    // Frame E: equal spikes (tie) and a later larger spike (R5)
    for (int i = 0; i < DIM*DIM; i++) frame[i] = 0;
    frame[5*DIM + 4] = 31;
    frame[5*DIM + 10] = 31;
    frame[9*DIM + 3] = 20;
    frame[10*DIM + 7] = 25;
    drive_frame(0, -1);
    finish_frame(0, "R5");
    rd(0, 1, v);
    check(v == 5*DIM + 4, "R5", "tie keeps earlier spike", v, 5*DIM + 4);
    rd(0, 2, v);
    check(v == 10*DIM + 7, "R5", "larger later spike wins", v, 10*DIM + 7);

    // Frames F (abandoned) then G (restart with sof) -> bank 1 (R10)
    fill_rand(31);
    d0 = n_done;
    drive_frame(0, 170);
    @(negedge clk);
    px_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(n_done == d0, "R10", "no done for partial frame", n_done, d0);
    check(fill_bank == 1'b1, "R10", "bank kept after partial frame", fill_bank, 1);
    fill_rand(3);
    drive_frame(0, -1);
    finish_frame(1, "R10");
    check(n_done == d0 + 1, "R10", "one done after restart", n_done, d0 + 1);

    // Frame H: random again with idle cycles -> bank 0 (R2, R6)
    fill_rand(31);
    drive_frame(50, -1);
    finish_frame(0, "R6");

    report();
  end

endmodule